// File: doc/BRIEF.md
# Internal Data Memory Address Steering

This block holds the 192-byte on-chip data RAM of a small controller core and decides, for every byte access, whether the access lands in that RAM or goes out to the special-function-register (SFR) side. The decision depends on the 8-bit address and on whether the access uses direct or indirect addressing. In the lower half of the space, 00h to 7Fh, both modes reach RAM. In the upper half, the mode picks the resource. Direct accesses to 80h–FFh go to the SFR port. Indirect accesses to 80h–BFh reach the upper RAM bytes. Indirect accesses to C0h–FFh have no backing storage.

The core drives one access per cycle with plain read and write strobes. Read data appears on the cycle after the read strobe. The SFR side receives a pass-through address and write data, plus a one-cycle read or write strobe. It must return its read data on the cycle after an SFR read strobe. No back-pressure exists on either side: every strobe is taken in the cycle it is raised.

Top module: `dmem_steer`

## Requirements
- R1: While rst_n is low, sfr_rd and sfr_wr are 0 whatever the access inputs do. After reset, rd_data reads FFh until the first read.
- R2: Addresses 00h–7Fh reach RAM in both modes (acc_indirect = 0 direct, 1 indirect). A byte written in one mode reads back in the other, and no SFR strobe is raised.
- R3: Indirect accesses to 80h–BFh read and write the upper RAM bytes and raise no SFR strobe.
- R4: A direct access with address bit 7 set (80h–FFh) leaves RAM untouched. It raises sfr_wr for a write or sfr_rd for a read, with sfr_addr equal to the access address and sfr_wdata equal to the write data.
- R5: An indirect read of C0h–FFh returns FFh. An indirect write there changes nothing and raises no SFR strobe.
- R6: At most one SFR strobe is high in any cycle. A direct access to 80h–FFh with both acc_rd and acc_wr set raises only sfr_wr, and its read returns FFh.
- R7: Read data appears on rd_data on the cycle after acc_rd. For the SFR region it is the sfr_rdata presented in that cycle.
- R8: A read and a write to the same RAM byte in one cycle return the byte's old value. The new value is seen by the next read.
- R9: Reset does not clear RAM contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_addr | input | 8 | Byte address of the access |
| acc_indirect | input | 1 | 1 = indirect addressing, 0 = direct |
| acc_rd | input | 1 | Read strobe |
| acc_wr | input | 1 | Write strobe |
| acc_wdata | input | 8 | Write data |
| rd_data | output | 8 | Read result, valid the cycle after acc_rd |
| sfr_addr | output | 8 | Address presented to the SFR side |
| sfr_wdata | output | 8 | Write data presented to the SFR side |
| sfr_rd | output | 1 | SFR read strobe |
| sfr_wr | output | 1 | SFR write strobe |
| sfr_rdata | input | 8 | SFR read data, valid the cycle after sfr_rd |

## Verification
The bench aims at the overlap range 80h–BFh. It writes the same address once directly and once indirectly, then reads both back. A design that ignored the mode would let the SFR write corrupt RAM, or would send the indirect write out as a strobe. It reads and writes the void range C0h–FFh indirectly, where a decoder that wrapped the index would alias lower RAM bytes. It also covers two timing corners: a same-cycle read and write, which a write-first RAM would get wrong, and a combined read and write to the SFR region, which a careless design would answer with two strobes. Reset is exercised twice: once to check that strobes are held off while the access inputs are active, and once to check that RAM survives reset.

// File: rtl/dmem_pkg.sv
package dmem_pkg;
  // Where an access lands after address and mode decoding.
  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_RAM  = 2'd1,
    TGT_SFR  = 2'd2
  } tgt_e;
endpackage

// File: rtl/dmem_route.sv
module dmem_route
  import dmem_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int RAM_BYTES = 192,
  parameter int SFR_BASE  = 128
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              indirect,
  output tgt_e              tgt
);
  localparam logic [ADDR_W:0] RAM_END  = RAM_BYTES[ADDR_W:0];
  localparam logic [ADDR_W:0] SFR_LOW  = SFR_BASE[ADDR_W:0];

  logic [ADDR_W:0] a_ext;
  assign a_ext = {1'b0, addr};

  always_comb begin
    if (!indirect && (a_ext >= SFR_LOW))
      tgt = TGT_SFR;       // direct upper half: SFR only
    else if (a_ext < RAM_END)
      tgt = TGT_RAM;       // low half any mode, overlap band indirect
    else
      tgt = TGT_NONE;      // indirect above RAM: nothing there
  end
endmodule

// File: rtl/dmem_array.sv
module dmem_array #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 192,
  parameter int AW     = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic              re,
  input  logic [AW-1:0]     addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  // Read samples the array before this edge's write lands: old data on collision.
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) rdata <= mem[addr];
  end
endmodule

// File: rtl/dmem_rmux.sv
module dmem_rmux
  import dmem_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_fire,
  input  tgt_e              rd_tgt,
  input  logic [DATA_W-1:0] ram_q,
  input  logic [DATA_W-1:0] sfr_q,
  output logic [DATA_W-1:0] rd_data
);
  tgt_e sel_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       sel_q <= TGT_NONE;
    else if (rd_fire) sel_q <= rd_tgt;
  end

  always_comb begin
    unique case (sel_q)
      TGT_RAM: rd_data = ram_q;
      TGT_SFR: rd_data = sfr_q;
      default: rd_data = '1;
    endcase
  end
endmodule

// File: rtl/dmem_steer.sv
module dmem_steer
  import dmem_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 8,
  parameter int RAM_BYTES = 192,
  parameter int SFR_BASE  = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_indirect,
  input  logic              acc_rd,
  input  logic              acc_wr,
  input  logic [DATA_W-1:0] acc_wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] sfr_addr,
  output logic [DATA_W-1:0] sfr_wdata,
  output logic              sfr_rd,
  output logic              sfr_wr,
  input  logic [DATA_W-1:0] sfr_rdata
);
  localparam int RAM_AW = $clog2(RAM_BYTES);

  tgt_e             tgt;
  tgt_e             rd_tgt;
  logic             ram_we;
  logic             ram_re;
  logic [DATA_W-1:0] ram_q;

  dmem_route #(
    .ADDR_W   (ADDR_W),
    .RAM_BYTES(RAM_BYTES),
    .SFR_BASE (SFR_BASE)
  ) u_route (
    .addr    (acc_addr),
    .indirect(acc_indirect),
    .tgt     (tgt)
  );

  assign ram_we = rst_n && acc_wr && (tgt == TGT_RAM);
  assign ram_re = rst_n && acc_rd && (tgt == TGT_RAM);

  dmem_array #(
    .DATA_W(DATA_W),
    .DEPTH (RAM_BYTES),
    .AW    (RAM_AW)
  ) u_array (
    .clk  (clk),
    .we   (ram_we),
    .re   (ram_re),
    .addr (acc_addr[RAM_AW-1:0]),
    .wdata(acc_wdata),
    .rdata(ram_q)
  );

  // SFR side: a combined read+write issues only the write strobe.
  assign sfr_addr  = acc_addr;
  assign sfr_wdata = acc_wdata;
  assign sfr_wr    = rst_n && acc_wr && (tgt == TGT_SFR);
  assign sfr_rd    = rst_n && acc_rd && !acc_wr && (tgt == TGT_SFR);

  assign rd_tgt = ((tgt == TGT_SFR) && acc_wr) ? TGT_NONE : tgt;

  dmem_rmux #(
    .DATA_W(DATA_W)
  ) u_rmux (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_fire(acc_rd),
    .rd_tgt (rd_tgt),
    .ram_q  (ram_q),
    .sfr_q  (sfr_rdata),
    .rd_data(rd_data)
  );
endmodule

// File: rtl/dmem_steer_chk.sv
module dmem_steer_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] acc_addr,
  input logic              acc_indirect,
  input logic              acc_rd,
  input logic              acc_wr,
  input logic [DATA_W-1:0] acc_wdata,
  input logic [DATA_W-1:0] rd_data,
  input logic [ADDR_W-1:0] sfr_addr,
  input logic              sfr_rd,
  input logic              sfr_wr
);
  // R1: strobes held off during reset
  always @(posedge clk) begin
    if (!rst_n) assert_strobe_reset_R1: assert (!sfr_rd && !sfr_wr);
  end

  assert_strobe_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(sfr_rd && sfr_wr));

  assert_no_sfr_indirect_R3: assert property (@(posedge clk) disable iff (!rst_n)
    acc_indirect |-> (!sfr_rd && !sfr_wr));

  assert_sfr_upper_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sfr_rd || sfr_wr) |-> (sfr_addr[ADDR_W-1] && (sfr_addr == acc_addr)));

  assert_direct_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr && !acc_indirect && acc_addr[ADDR_W-1]) |-> sfr_wr);

  assert_void_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_rd && acc_indirect && (acc_addr[ADDR_W-1:ADDR_W-2] == 2'b11)) |=> (rd_data == '1));
endmodule

bind dmem_steer dmem_steer_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_addr(acc_addr), .acc_indirect(acc_indirect),
  .acc_rd(acc_rd), .acc_wr(acc_wr), .acc_wdata(acc_wdata), .rd_data(rd_data),
  .sfr_addr(sfr_addr), .sfr_rd(sfr_rd), .sfr_wr(sfr_wr)
);

// File: tb/tb_dmem_steer.sv
module tb_dmem_steer;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [7:0] acc_addr = 0;
  logic       acc_indirect = 0;
  logic       acc_rd = 0;
  logic       acc_wr = 0;
  logic [7:0] acc_wdata = 0;
  logic [7:0] rd_data;
  logic [7:0] sfr_addr;
  logic [7:0] sfr_wdata;
  logic       sfr_rd;
  logic       sfr_wr;
  logic [7:0] sfr_rdata = 8'h00;

  int checks = 0;
  int errors = 0;
  int sfr_wr_cnt = 0;
  int sfr_rd_cnt = 0;
  logic [7:0] sfr_regs [256];

  always #5 clk = ~clk;

  dmem_steer dut (
    .clk(clk), .rst_n(rst_n), .acc_addr(acc_addr), .acc_indirect(acc_indirect),
    .acc_rd(acc_rd), .acc_wr(acc_wr), .acc_wdata(acc_wdata), .rd_data(rd_data),
    .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata), .sfr_rd(sfr_rd), .sfr_wr(sfr_wr),
    .sfr_rdata(sfr_rdata)
  );

  // Bench model of the SFR side: registered read, counted strobes.
  always @(posedge clk) begin
    if (sfr_wr) begin
      sfr_regs[sfr_addr] <= sfr_wdata;
      sfr_wr_cnt <= sfr_wr_cnt + 1;
    end
    if (sfr_rd) begin
      sfr_rdata <= sfr_regs[sfr_addr];
      sfr_rd_cnt <= sfr_rd_cnt + 1;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // One access: drive at negedge, strobe for one edge, sample at next negedge.
  task automatic access(input logic [7:0] a, input logic ind, input logic rd,
                        input logic wr, input logic [7:0] d, output logic [7:0] q);
    acc_addr = a; acc_indirect = ind; acc_rd = rd; acc_wr = wr; acc_wdata = d;
    @(negedge clk);
    acc_rd = 0; acc_wr = 0;
    q = rd_data;
  endtask

  task automatic t_reset_state();
    logic [7:0] q;
    // R1: strobes stay low during reset while a direct SFR write is driven
    rst_n = 0;
    acc_addr = 8'h90; acc_indirect = 0; acc_wr = 1; acc_rd = 1;
    @(negedge clk);
    check("R1 sfr_wr in reset", sfr_wr, 0);
    check("R1 sfr_rd in reset", sfr_rd, 0);
    @(negedge clk);
    acc_wr = 0; acc_rd = 0;
    rst_n = 1;
    @(negedge clk);
    check("R1 rd_data after reset", rd_data, 8'hFF);
    check("R1 no strobes counted", sfr_wr_cnt + sfr_rd_cnt, 0);
    q = 0;
  endtask

  task automatic t_low_ram();
    logic [7:0] q;
    access(8'h10, 0, 0, 1, 8'hA5, q);
    access(8'h10, 1, 1, 0, 8'h00, q);
    check("R2 direct write, indirect read", q, 8'hA5);
    access(8'h7F, 1, 0, 1, 8'h5A, q);
    access(8'h7F, 0, 1, 0, 8'h00, q);
    check("R2 indirect write, direct read", q, 8'h5A);
    access(8'h00, 0, 0, 1, 8'h01, q);
    access(8'h00, 0, 1, 0, 8'h00, q);
    check("R7 one-cycle read latency", q, 8'h01);
    check("R2 no SFR strobe", sfr_wr_cnt + sfr_rd_cnt, 0);
  endtask

  task automatic t_overlap();
    logic [7:0] q;
    int w0;
    int r0;
    access(8'h85, 1, 0, 1, 8'h3C, q);
    access(8'hBF, 1, 0, 1, 8'h77, q);
    check("R3 indirect upper no strobe", sfr_wr_cnt + sfr_rd_cnt, 0);
    w0 = sfr_wr_cnt;
    access(8'h85, 0, 0, 1, 8'hC3, q);
    check("R4 direct write raises sfr_wr", sfr_wr_cnt - w0, 1);
    check("R4 SFR received data", sfr_regs[8'h85], 8'hC3);
    access(8'h85, 1, 1, 0, 8'h00, q);
    check("R4 RAM 85h untouched / R3 readback", q, 8'h3C);
    access(8'hBF, 1, 1, 0, 8'h00, q);
    check("R3 indirect BFh readback", q, 8'h77);
    r0 = sfr_rd_cnt;
    access(8'h85, 0, 1, 0, 8'h00, q);
    check("R4 direct read raises sfr_rd", sfr_rd_cnt - r0, 1);
    check("R7 direct read returns SFR data", q, 8'hC3);
  endtask

  task automatic t_void();
    logic [7:0] q;
    int s0;
    s0 = sfr_wr_cnt + sfr_rd_cnt;
    access(8'hC0, 1, 0, 1, 8'h12, q);
    access(8'hC0, 1, 1, 0, 8'h00, q);
    check("R5 indirect C0h reads FFh", q, 8'hFF);
    access(8'hFF, 1, 1, 0, 8'h00, q);
    check("R5 indirect FFh reads FFh", q, 8'hFF);
    check("R5 no strobe in void", sfr_wr_cnt + sfr_rd_cnt - s0, 0);
    access(8'h00, 1, 1, 0, 8'h00, q);
    check("R5 write did not alias 00h", q, 8'h01);
  endtask

  task automatic t_sfr_rmw();
    logic [7:0] q;
    int w0;
    int r0;
    w0 = sfr_wr_cnt; r0 = sfr_rd_cnt;
    access(8'hA0, 0, 1, 1, 8'h66, q);
    check("R6 only sfr_wr counted", sfr_wr_cnt - w0, 1);
    check("R6 no sfr_rd", sfr_rd_cnt - r0, 0);
    check("R6 read returns FFh", q, 8'hFF);
  endtask

  task automatic t_collision();
    logic [7:0] q;
    access(8'h20, 0, 0, 1, 8'h11, q);
    access(8'h20, 0, 1, 1, 8'h22, q);
    check("R8 same-cycle read gets old", q, 8'h11);
    access(8'h20, 1, 1, 0, 8'h00, q);
    check("R8 next read gets new", q, 8'h22);
  endtask

  task automatic t_retain();
    logic [7:0] q;
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    access(8'h10, 0, 1, 0, 8'h00, q);
    check("R9 RAM 10h kept across reset", q, 8'hA5);
    access(8'h85, 1, 1, 0, 8'h00, q);
    check("R9 RAM 85h kept across reset", q, 8'h3C);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) sfr_regs[i] = 8'h00;
    fork
      begin
        @(negedge clk);
        t_reset_state();
        t_low_ram();
        t_overlap();
        t_void();
        t_sfr_rmw();
        t_collision();
        t_retain();
      end
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule